// File: doc/BRIEF.md
# Posted-Write Watchdog Timer

This block is a 32-bit up-counting watchdog driven by a slow timer tick (nominally 32.768 kHz, given to the block as a one-cycle enable on the system clock). Software reaches it through a plain register bus made of a write port and a combinational read port. The counter can be slowed by an optional power-of-two prescaler. When the counter wraps past all ones, the block raises a one-cycle reset request, reloads the counter from the load register and keeps running. To set a timeout of N seconds at prescale P, software loads all-ones minus N·(32768 >> P) plus one.

Every write to a configuration register is posted. The bus write is taken into a shadow slot at once, and a per-register pending flag rises. The new value takes effect in the timer domain on the third timer tick after the bus write was accepted, and the flag clears on that same tick. Software polls the pending register before it writes the same register again.

Counting is started and stopped only through a two-word key sequence written to the run-control register. A trigger register lets software kick the watchdog: writing a value that differs from the last one reloads the counter.

Top module: `wdog_posted`

## Requirements
- R1: After reset the counter is stopped and reads zero. The load, trigger, control and pending registers read zero, and `rst_req` is low.
- R2: A bus write to control, load, trigger or run-control sets that register's pending flag in the next cycle. The flags are pending-register bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for run-control. The flag stays set through the first two timer ticks after the write. On the third tick the register takes the written value and the flag clears.
- R3: A bus write to a register whose pending flag is set is ignored, so the earlier value is the one applied.
- R4: The counter starts only after run-control receives 0xBBBB and then 0x4444 as consecutive applied words. A word matches only when bits 31:16 are zero.
- R5: The counter stops only after run-control receives 0xAAAA and then 0x5555 as consecutive applied words.
- R6: If the second word of a start or stop sequence is wrong, or a second word arrives without its first word, the sequence returns to idle and the running state does not change.
- R7: The control register keeps only bit 5 (prescaler enable) and bits 4:2 (prescale exponent P). While running, the counter advances by one on every tick when the prescaler is off, and once every 2^P ticks when it is on. The prescale phase restarts when a control write is applied. A stopped counter holds its value.
- R8: On the tick where the counter wraps past 0xFFFFFFFF, the counter is reloaded from the load register and `rst_req` is high for exactly the following cycle. The counter keeps running.
- R9: An applied trigger write whose value differs from the trigger register's current content reloads the counter from the load register. An applied trigger write with the same value has no effect on the counter.
- R10: Read addresses: 0 control, 1 load, 2 trigger, 3 run-control (bit 0 is the running state), 4 pending flags, 5 counter. The same addresses 0 to 3 select the register on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timer tick enable (32.768 kHz rate) |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Bus write register address |
| wr_data | input | CW | Bus write data |
| rd_addr | input | AW | Bus read register address |
| rd_data | output | CW | Combinational read data |
| rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
A slot whose delay counter is off by one shows as a pending flag that clears one tick early or late, so the pending read exposes it within three ticks of any write. A handshake left in the wrong armed state shows as a start or stop caused by a lone second word. That is visible at the running bit and the counter on the next applied run-control write. A wrong wrap or reload path shows as a missing or doubled `rst_req`, or as a counter value other than the load value in the cycle after the sixteenth tick from a load of 0xFFFFFFF0. A trigger compare that is inverted shows within three ticks, because the counter jumps back to the load value when it should have kept counting.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // register addresses
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_LOAD = 1;
  localparam int unsigned REG_TRIG = 2;
  localparam int unsigned REG_RUN  = 3;
  localparam int unsigned REG_PEND = 4;
  localparam int unsigned REG_CNT  = 5;
  localparam int unsigned NSLOT    = 4;

  // control field layout
  localparam int unsigned CTRL_PRE_BIT = 5;
  localparam int unsigned CTRL_PTV_LSB = 2;

  // run-control keys
  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {HS_IDLE, HS_ON_ARMED, HS_OFF_ARMED} hs_state_e;

  typedef struct packed {
    hs_state_e st;
    logic      run;
  } hs_t;

  // pending-register bit that belongs to each slot
  function automatic int unsigned pend_bit(int unsigned slot);
    case (slot)
      REG_CTRL: return 0;
      REG_LOAD: return 2;
      REG_TRIG: return 3;
      default:  return 4;
    endcase
  endfunction

  // one step of the start/stop key sequence
  function automatic hs_t hs_step(hs_state_e st, logic run, logic [15:0] w);
    hs_t r;
    r.st  = HS_IDLE;
    r.run = run;
    if (st == HS_ON_ARMED && w == KEY_ON2) r.run = 1'b1;
    if (st == HS_OFF_ARMED && w == KEY_OFF2) r.run = 1'b0;
    if (w == KEY_ON1) r.st = HS_ON_ARMED;
    else if (w == KEY_OFF1) r.st = HS_OFF_ARMED;
    return r;
  endfunction

endpackage

// File: rtl/wdp_post_slot.sv
module wdp_post_slot #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req,
  input  logic [DW-1:0] req_data,
  output logic          pend,
  output logic          fire,
  output logic [DW-1:0] data
);
  localparam int unsigned TW = $clog2(LAT + 1);

  logic [TW-1:0] ticks;

  assign fire = pend && tick && (ticks == TW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ticks <= '0;
      data  <= '0;
    end else if (req && !pend) begin
      pend  <= 1'b1;
      ticks <= '0;
      data  <= req_data;
    end else if (pend && tick) begin
      if (fire) pend <= 1'b0;
      ticks <= ticks + 1'b1;
    end
  end

  AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n) fire |=> !pend); // R2
  AST_POST_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (req && !pend) |=> pend); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n) (req && pend) |=> $stable(data)); // R3

endmodule

// File: rtl/wdp_keyseq.sv
module wdp_keyseq
  import wdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [15:0] word,
  output logic        running
);
  hs_state_e st;
  hs_t       nxt;

  always_comb nxt = hs_step(st, running, word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= HS_IDLE;
      running <= 1'b0;
    end else if (fire) begin
      st      <= nxt.st;
      running <= nxt.run;
    end
  end

  AST_RUN_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(running) |-> $past(fire)); // R6
  AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n) $rose(running) |-> ($past(word) == KEY_ON2)); // R4
  AST_STOP_KEY: assert property (@(posedge clk) disable iff (!rst_n) $fell(running) |-> ($past(word) == KEY_OFF2)); // R5

endmodule

// File: rtl/wdp_timer_core.sv
module wdp_timer_core #(
  parameter int unsigned CW   = 32,
  parameter int unsigned PTVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            running,
  input  logic            pre_en,
  input  logic [PTVW-1:0] ptv,
  input  logic            div_clr,
  input  logic            reload,
  input  logic [CW-1:0]   load_val,
  output logic [CW-1:0]   count,
  output logic            rst_req
);
  localparam int unsigned DIVW = (1 << PTVW) - 1;

  logic [DIVW-1:0] div;
  logic            adv;
  logic            wrap;

  function automatic logic step_ok(logic [DIVW-1:0] d, logic pe, logic [PTVW-1:0] p);
    logic [DIVW:0] lim;
    lim = ((DIVW+1)'(1) << p) - (DIVW+1)'(1);
    return !pe || ({1'b0, d} == lim);
  endfunction

  assign adv  = tick && running && step_ok(div, pre_en, ptv);
  assign wrap = adv && (count == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      div     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap && !reload;
      if (reload || wrap) count <= load_val;
      else if (adv)       count <= count + 1'b1;
      if (div_clr) div <= '0;
      else if (tick && running && pre_en) div <= adv ? '0 : div + 1'b1;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R8
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> (count == $past(load_val))); // R8
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!running && !reload) |=> $stable(count)); // R7

endmodule

// File: rtl/wdog_posted.sv
module wdog_posted
  import wdp_pkg::*;
#(
  parameter int unsigned CW   = 32,
  parameter int unsigned AW   = 3,
  parameter int unsigned LAT  = 3,
  parameter int unsigned PTVW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          rst_req
);
  logic [NSLOT-1:0] slot_pend;
  logic [NSLOT-1:0] slot_fire;
  logic [CW-1:0]    slot_data [NSLOT];
  logic [CW-1:0]    pend_vec;

  logic            ctrl_pre;
  logic [PTVW-1:0] ctrl_ptv;
  logic [CW-1:0]   load_q;
  logic [CW-1:0]   trig_q;
  logic            running;
  logic            reload;
  logic            run_hi_clear;
  logic [15:0]     run_word;
  logic [CW-1:0]   count;
  logic            unused_ctrl;

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      wdp_post_slot #(.DW(CW), .LAT(LAT)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .req      (wr_en && (wr_addr == AW'(gi))),
        .req_data (wr_data),
        .pend     (slot_pend[gi]),
        .fire     (slot_fire[gi]),
        .data     (slot_data[gi])
      );
    end
  endgenerate

  always_comb begin
    pend_vec = '0;
    for (int i = 0; i < NSLOT; i++) pend_vec[pend_bit(i)] = slot_pend[i];
  end

  // applied registers in the timer domain
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_pre <= 1'b0;
      ctrl_ptv <= '0;
      load_q   <= '0;
      trig_q   <= '0;
    end else begin
      if (slot_fire[REG_CTRL]) begin
        ctrl_pre <= slot_data[REG_CTRL][CTRL_PRE_BIT];
        ctrl_ptv <= slot_data[REG_CTRL][CTRL_PTV_LSB +: PTVW];
      end
      if (slot_fire[REG_LOAD]) load_q <= slot_data[REG_LOAD];
      if (slot_fire[REG_TRIG]) trig_q <= slot_data[REG_TRIG];
    end
  end

  assign unused_ctrl = &{1'b0, slot_data[REG_CTRL][CW-1:CTRL_PRE_BIT+1],
                         slot_data[REG_CTRL][CTRL_PTV_LSB-1:0]};

  assign reload       = slot_fire[REG_TRIG] && (slot_data[REG_TRIG] != trig_q);
  assign run_hi_clear = ~|slot_data[REG_RUN][CW-1:16];
  assign run_word     = run_hi_clear ? slot_data[REG_RUN][15:0] : 16'h0000;

  wdp_keyseq u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (slot_fire[REG_RUN]),
    .word    (run_word),
    .running (running)
  );

  wdp_timer_core #(.CW(CW), .PTVW(PTVW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .running  (running),
    .pre_en   (ctrl_pre),
    .ptv      (ctrl_ptv),
    .div_clr  (slot_fire[REG_CTRL]),
    .reload   (reload),
    .load_val (load_q),
    .count    (count),
    .rst_req  (rst_req)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(REG_CTRL): begin
        rd_data[CTRL_PRE_BIT]             = ctrl_pre;
        rd_data[CTRL_PTV_LSB +: PTVW]     = ctrl_ptv;
      end
      AW'(REG_LOAD): rd_data = load_q;
      AW'(REG_TRIG): rd_data = trig_q;
      AW'(REG_RUN):  rd_data[0] = running;
      AW'(REG_PEND): rd_data = pend_vec;
      AW'(REG_CNT):  rd_data = count;
      default:       rd_data = '0;
    endcase
  end

  AST_SAME_TRIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire[REG_TRIG] && slot_data[REG_TRIG] == trig_q && !running) |=> $stable(count)); // R9
  AST_PEND_DROPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_vec[pend_bit(REG_LOAD)]) |-> $past(tick)); // R2

endmodule

// File: tb/sim_wdog_posted.sv
module sim_wdog_posted;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  int tdiv = 0;
  bit done = 1'b0;

  wdog_posted u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  // tick every fourth clock
  always @(negedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    tick <= (tdiv == 2);
  end

  // {addr, pend bit, write data, expected readback}
  localparam logic [69:0] VEC [6] = '{
    {3'd1, 3'd2, 32'hFFFF0000, 32'hFFFF0000},
    {3'd0, 3'd0, 32'h0000003C, 32'h0000003C},
    {3'd0, 3'd0, 32'hFFFFFFFF, 32'h0000003C},
    {3'd0, 3'd0, 32'h00000020, 32'h00000020},
    {3'd1, 3'd2, 32'h12345678, 32'h12345678},
    {3'd0, 3'd0, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_idle(input int pb);
    logic [31:0] p;
    for (int i = 0; i < 60; i++) begin
      rd(3'd4, p);
      if (!p[pb]) break;
      @(negedge clk);
    end
  endtask

  task automatic wr_posted(input logic [2:0] a, input logic [31:0] d);
    int pb;
    pb = (a == 3'd0) ? 0 : (a == 3'd1) ? 2 : (a == 3'd2) ? 3 : 4;
    bus_write(a, d);
    wait_idle(pb);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
    end
    chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);

    // R2 / R7 / R10 posted write table
    for (int k = 0; k < 6; k++) begin
      logic [2:0] a;
      logic [2:0] pb;
      a  = VEC[k][69:67];
      pb = VEC[k][66:64];
      bus_write(a, VEC[k][63:32]);
      rd(3'd4, v);
      chk("R2 pend set", {31'b0, v[pb]}, 32'h1);
      tick_edges(2);
      rd(3'd4, v);
      chk("R2 pend held two ticks", {31'b0, v[pb]}, 32'h1);
      tick_edges(1);
      rd(3'd4, v);
      chk("R2 pend clear third tick", v, 32'h0);
      rd(a, v);
      chk("R7 R10 applied value", v, VEC[k][31:0]);
    end

    // R3 write while pending ignored
    bus_write(3'd1, 32'hFFFFFFF0);
    bus_write(3'd1, 32'h00000001);
    wait_idle(2);
    rd(3'd1, v);
    chk("R3 busy write dropped", v, 32'hFFFFFFF0);

    // R6 broken start sequences
    wr_posted(3'd3, 32'h4444);
    rd(3'd3, v);
    chk("R6 lone second word", v, 32'h0);
    wr_posted(3'd3, 32'hBBBB);
    wr_posted(3'd3, 32'h1234);
    wr_posted(3'd3, 32'h4444);
    rd(3'd3, v);
    chk("R6 wrong second word", v, 32'h0);
    wr_posted(3'd3, 32'hBBBB);
    wr_posted(3'd3, 32'h0001_4444);
    rd(3'd3, v);
    chk("R4 upper bits must be zero", v, 32'h0);
    rd(3'd5, v);
    chk("R7 stopped counter holds", v, 32'h0);

    // R4 start
    wr_posted(3'd3, 32'hBBBB);
    wr_posted(3'd3, 32'h4444);
    rd(3'd3, v);
    chk("R4 running after start keys", v, 32'h1);
    rd(3'd5, c0);
    tick_edges(1);
    rd(3'd5, v);
    chk("R7 one step per tick", v, c0 + 1);

    // R9 trigger reload then R8 wrap
    wr_posted(3'd2, 32'h5);
    rd(3'd5, v);
    chk("R9 trigger reload", v, 32'hFFFFFFF0);
    for (int k = 1; k <= 16; k++) begin
      tick_edges(1);
      if (k < 16) begin
        if (rst_req !== 1'b0) chk("R8 early rst_req", {31'b0, rst_req}, 32'h0);
      end else begin
        chk("R8 rst_req on wrap", {31'b0, rst_req}, 32'h1);
        rd(3'd5, v);
        chk("R8 reload on wrap", v, 32'hFFFFFFF0);
      end
    end
    @(negedge clk);
    chk("R8 rst_req one cycle", {31'b0, rst_req}, 32'h0);
    rd(3'd3, v);
    chk("R8 keeps running", v, 32'h1);

    // R9 same value no reload
    bus_write(3'd2, 32'h5);
    rd(3'd5, c0);
    tick_edges(3);
    rd(3'd5, v);
    chk("R9 same trigger no reload", v, c0 + 3);
    wr_posted(3'd2, 32'h6);
    rd(3'd5, v);
    chk("R9 new trigger reloads", v, 32'hFFFFFFF0);

    // R7 prescaler P=2
    wr_posted(3'd1, 32'h0);
    wr_posted(3'd2, 32'h9);
    wr_posted(3'd0, 32'h28);
    rd(3'd5, c0);
    tick_edges(3);
    rd(3'd5, v);
    chk("R7 prescaled hold", v, c0);
    tick_edges(1);
    rd(3'd5, v);
    chk("R7 prescaled step", v, c0 + 1);

    // R6 broken stop, R5 stop
    wr_posted(3'd3, 32'hAAAA);
    wr_posted(3'd3, 32'h1111);
    wr_posted(3'd3, 32'h5555);
    rd(3'd3, v);
    chk("R6 broken stop keeps running", v, 32'h1);
    wr_posted(3'd3, 32'hAAAA);
    wr_posted(3'd3, 32'h5555);
    rd(3'd3, v);
    chk("R5 stopped after keys", v, 32'h0);
    rd(3'd5, c0);
    tick_edges(8);
    rd(3'd5, v);
    chk("R5 counter frozen", v, c0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule